// File: doc/BRIEF.md
# Low-Side Gate Short-Circuit Monitor

This block supervises the low-side gate outputs of a three-phase half-bridge driver. For each phase it compares the commanded low-side gate state with a digital flag from an external comparator. The flag reports whether the sensed gate voltage is above a fixed threshold. After every change of command, the sensed level must follow within a window of clock cycles set by a parameter. This holds for both directions: rising when the gate is switched on, and falling when it is switched off. If a phase misses the window while monitoring is armed, the block declares a short-circuit fault.

A fault sets one shared sticky status flag and raises the interrupt line. It also drops the driver-enable output, so the gate driver stage is shut down. An optional capture vector records which phases timed out. The flag is released only by a fixed sequence: first disarm monitoring through the enable register, then write one to the clear strobe. The comparator flags pass through a synchronizer, and the window accounts for that delay.

Top module: `gate_sc_monitor`

## Requirements
- R1: After reset, `mon_en`, `fault_sts`, `irq` and `fault_chan` are 0 and `drv_en` is 1.
- R2: A cycle with `en_we` = 1 loads `en_wd` into the enable register, and `mon_en` shows the new value after that clock edge.
- R3: When `cmd_lo[i]` goes 0→1 and `cmp_hi[i]` goes 1 D cycles later (D = 0 means in the same cycle), a fault is declared exactly when D > TIMEOUT_CYC − SYNC_STAGES. A declared fault makes `fault_sts` 1 on the (TIMEOUT_CYC+1)-th clock edge after the edge that first sees the new command, and `fault_sts` is 0 on all earlier edges.
- R4: The same rule and the same timing as R3 apply when `cmd_lo[i]` goes 1→0 and `cmp_hi[i]` must go to 0.
- R5: While `mon_en` is 0, no fault is declared, even if a comparator never follows its command.
- R6: When a fault is declared, `fault_sts` and `irq` become 1 together and `drv_en` becomes 0. All three keep these values after the comparator recovers and until R7's clear takes effect.
- R7: A `clr_w1c` pulse clears the fault (`fault_sts` = 0, `irq` = 0, `drv_en` = 1) only when `mon_en` is already 0 at that clock edge. A pulse while `mon_en` is 1 has no effect, and this includes a pulse in the same cycle as a write of 0 to the enable register.
- R8: Bit i of `fault_chan` is 1 when phase i timed out. Phases that time out in the same cycle all set their bits, and they share one `fault_sts` and one `irq`. A clear per R7 zeroes `fault_chan`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_lo | input | NUM_CH | Commanded low-side gate states, 1 = on |
| cmp_hi | input | NUM_CH | Comparator flags, 1 = sensed gate voltage above threshold (asynchronous) |
| en_we | input | 1 | Enable register write strobe |
| en_wd | input | 1 | Enable register write data |
| clr_w1c | input | 1 | Write-one strobe to clear the fault status |
| mon_en | output | 1 | Enable register value (monitoring armed) |
| fault_sts | output | 1 | Sticky short-circuit fault status |
| irq | output | 1 | Interrupt request |
| drv_en | output | 1 | Driver enable, 0 after a fault |
| fault_chan | output | NUM_CH | Per-phase capture of the phases that timed out |

## Verification
The bench sweeps every phase in both switching directions. For each, the comparator response delay runs from zero to beyond the window. This separates responses that arrive on the last allowed cycle from those one cycle late, and it pins the cycle on which the fault appears. Further cases check a late response with monitoring disarmed, and a status that stays set after the gate voltage recovers. They also check a clear attempted while armed, in the same cycle as the disarming write, and after it. A simultaneous timeout on two phases checks that the capture vector records both while only one status and interrupt are raised.

// File: rtl/gsm_pkg.sv
package gsm_pkg;
  typedef enum logic {
    WIN_IDLE = 1'b0,
    WIN_OPEN = 1'b1
  } win_state_e;
endpackage

// File: rtl/gsm_sync.sv
module gsm_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= din;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/gsm_chan_timer.sv
module gsm_chan_timer
  import gsm_pkg::*;
#(
  parameter int TIMEOUT_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic cmd,
  input  logic sensed,
  input  logic arm,
  output logic timeout_o
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic          cmd_q;
  win_state_e    state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q     <= 1'b0;
      state     <= WIN_IDLE;
      cnt       <= '0;
      timeout_o <= 1'b0;
    end else begin
      cmd_q     <= cmd;
      timeout_o <= 1'b0;
      if (cmd != cmd_q) begin
        state <= WIN_OPEN;
        cnt   <= '0;
      end else if (state == WIN_OPEN) begin
        if (sensed == cmd_q) begin
          state <= WIN_IDLE;
        end else if (cnt == LAST) begin
          state     <= WIN_IDLE;
          timeout_o <= arm;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/gsm_fault_latch.sv
module gsm_fault_latch #(
  parameter int NUM_CH     = 3,
  parameter bit CAPTURE_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] hit,
  input  logic              en_q,
  input  logic              clr,
  output logic              sts,
  output logic              irq,
  output logic              drv_en,
  output logic [NUM_CH-1:0] cap
);
  logic any_hit;
  logic do_clr;

  assign any_hit = (|hit) && en_q;
  assign do_clr  = clr && !en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sts    <= 1'b0;
      irq    <= 1'b0;
      drv_en <= 1'b1;
    end else if (any_hit) begin
      sts    <= 1'b1;
      irq    <= 1'b1;
      drv_en <= 1'b0;
    end else if (do_clr) begin
      sts    <= 1'b0;
      irq    <= 1'b0;
      drv_en <= 1'b1;
    end
  end

  generate
    if (CAPTURE_EN) begin : g_cap
      always_ff @(posedge clk) begin
        if (rst)          cap <= '0;
        else if (any_hit) cap <= cap | hit;
        else if (do_clr)  cap <= '0;
      end
    end else begin : g_nocap
      assign cap = '0;
    end
  endgenerate
endmodule

// File: rtl/gate_sc_monitor.sv
module gate_sc_monitor #(
  parameter int NUM_CH      = 3,
  parameter int TIMEOUT_CYC = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit CAPTURE_EN  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] cmd_lo,
  input  logic [NUM_CH-1:0] cmp_hi,
  input  logic              en_we,
  input  logic              en_wd,
  input  logic              clr_w1c,
  output logic              mon_en,
  output logic              fault_sts,
  output logic              irq,
  output logic              drv_en,
  output logic [NUM_CH-1:0] fault_chan
);
  logic [NUM_CH-1:0] cmp_s;
  logic [NUM_CH-1:0] to_hit;
  logic              en_q;

  always_ff @(posedge clk) begin
    if (rst)        en_q <= 1'b0;
    else if (en_we) en_q <= en_wd;
  end
  assign mon_en = en_q;

  gsm_sync #(.W(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (cmp_hi),
    .dout(cmp_s)
  );

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      gsm_chan_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd_lo[i]),
        .sensed   (cmp_s[i]),
        .arm      (en_q),
        .timeout_o(to_hit[i])
      );
    end
  endgenerate

  gsm_fault_latch #(.NUM_CH(NUM_CH), .CAPTURE_EN(CAPTURE_EN)) u_latch (
    .clk   (clk),
    .rst   (rst),
    .hit   (to_hit),
    .en_q  (en_q),
    .clr   (clr_w1c),
    .sts   (fault_sts),
    .irq   (irq),
    .drv_en(drv_en),
    .cap   (fault_chan)
  );
endmodule

// File: rtl/gsm_checker.sv
module gsm_checker #(
  parameter int NUM_CH     = 3,
  parameter bit CAPTURE_EN = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              clr_w1c,
  input logic              mon_en,
  input logic              fault_sts,
  input logic              irq,
  input logic              drv_en,
  input logic [NUM_CH-1:0] fault_chan
);
  p_new_fault_needs_en_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_sts) |-> $past(mon_en));

  p_drv_off_r6: assert property (@(posedge clk) disable iff (rst)
    fault_sts |-> !drv_en);

  p_irq_with_sts_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_sts) |-> $rose(irq));

  p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (fault_sts && !(clr_w1c && !mon_en)) |=> fault_sts);

  p_clear_order_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(fault_sts) |-> ($past(clr_w1c) && !$past(mon_en)));

  p_cap_set_r8: assert property (@(posedge clk) disable iff (rst)
    fault_sts |-> ((CAPTURE_EN == 1'b0) || (fault_chan != '0)));

  p_cap_clear_r8: assert property (@(posedge clk) disable iff (rst)
    !fault_sts |-> (fault_chan == '0));
endmodule

bind gate_sc_monitor gsm_checker #(.NUM_CH(NUM_CH), .CAPTURE_EN(CAPTURE_EN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .clr_w1c   (clr_w1c),
  .mon_en    (mon_en),
  .fault_sts (fault_sts),
  .irq       (irq),
  .drv_en    (drv_en),
  .fault_chan(fault_chan)
);

// File: tb/test_gate_sc_monitor.sv
module test_gate_sc_monitor;
  localparam int NCH = 3;
  localparam int TO  = 8;
  localparam int SYN = 2;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] cmd_lo = '0;
  logic [NCH-1:0] cmp_hi = '0;
  logic           en_we = 1'b0;
  logic           en_wd = 1'b0;
  logic           clr_w1c = 1'b0;
  logic           mon_en, fault_sts, irq, drv_en;
  logic [NCH-1:0] fault_chan;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  gate_sc_monitor #(.NUM_CH(NCH), .TIMEOUT_CYC(TO), .SYNC_STAGES(SYN), .CAPTURE_EN(1'b1)) i_gate_sc_monitor (
    .clk(clk), .rst(rst), .cmd_lo(cmd_lo), .cmp_hi(cmp_hi),
    .en_we(en_we), .en_wd(en_wd), .clr_w1c(clr_w1c),
    .mon_en(mon_en), .fault_sts(fault_sts), .irq(irq),
    .drv_en(drv_en), .fault_chan(fault_chan)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr_en(input logic v);
    @(negedge clk); en_we = 1'b1; en_wd = v;
    @(negedge clk); en_we = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr_w1c = 1'b1;
    @(negedge clk); clr_w1c = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_seq(input string req);
    pulse_clr();
    check("R7", "sts after clear while armed", fault_sts, 1);
    check("R7", "drv_en after clear while armed", drv_en, 0);
    wr_en(1'b0);
    pulse_clr();
    check("R7", "sts after ordered clear", fault_sts, 0);
    check("R7", "irq after ordered clear", irq, 0);
    check("R7", "drv_en after ordered clear", drv_en, 1);
    check(req, "capture after ordered clear", fault_chan, 0);
    wr_en(1'b1);
  endtask

  task automatic run_edge(input int c, input logic nv, input int d, input string req);
    automatic bit ef = (d > TO - SYN);
    for (int i = 0; i <= TO + 3; i++) begin
      @(negedge clk);
      if (i == TO + 1) check(req, "sts before declare edge", fault_sts, 0);
      if (i == TO + 2) check(req, $sformatf("sts ch%0d d=%0d", c, d), fault_sts, int'(ef));
      if (i == 0) cmd_lo[c] = nv;
      if (i == d) cmp_hi[c] = nv;
    end
    check("R6", "irq", irq, int'(ef));
    check("R6", "drv_en", drv_en, int'(!ef));
    check("R8", "capture", fault_chan, ef ? (1 << c) : 0);
    if (ef) begin
      idle(5);
      check("R6", "sts held after recovery", fault_sts, 1);
      check("R6", "irq held after recovery", irq, 1);
      clear_seq("R8");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1", "mon_en", mon_en, 0);
    check("R1", "fault_sts", fault_sts, 0);
    check("R1", "irq", irq, 0);
    check("R1", "drv_en", drv_en, 1);
    check("R1", "fault_chan", fault_chan, 0);
    // R2 enable register
    wr_en(1'b1);
    check("R2", "mon_en after write 1", mon_en, 1);
    wr_en(1'b0);
    check("R2", "mon_en after write 0", mon_en, 0);
    wr_en(1'b1);
    check("R2", "mon_en after rewrite 1", mon_en, 1);

    // R3 / R4 sweep over phase and delay
    for (int c = 0; c < NCH; c++) begin
      for (int d = 0; d <= TO + 1; d++) begin
        run_edge(c, 1'b1, d, "R3");
        idle(2);
        run_edge(c, 1'b0, d, "R4");
        idle(2);
      end
    end

    // R5 disarmed: no fault even though comparator never follows
    wr_en(1'b0);
    @(negedge clk); cmd_lo[1] = 1'b1;
    idle(3 * TO);
    check("R5", "sts while disarmed", fault_sts, 0);
    check("R5", "drv_en while disarmed", drv_en, 1);
    check("R5", "capture while disarmed", fault_chan, 0);
    @(negedge clk); cmp_hi[1] = 1'b1;
    idle(4);
    wr_en(1'b1);

    // R8 two phases time out together
    @(negedge clk); cmd_lo[0] = 1'b1; cmd_lo[2] = 1'b1;
    idle(TO + 4);
    check("R8", "capture two phases", fault_chan, 5);
    check("R8", "shared sts", fault_sts, 1);
    check("R8", "shared irq", irq, 1);
    @(negedge clk); cmp_hi[0] = 1'b1; cmp_hi[2] = 1'b1;
    idle(4);
    // R7 clear in same cycle as disarming write is ignored
    @(negedge clk); en_we = 1'b1; en_wd = 1'b0; clr_w1c = 1'b1;
    @(negedge clk); en_we = 1'b0; clr_w1c = 1'b0;
    check("R7", "sts after same-cycle clear", fault_sts, 1);
    check("R7", "mon_en after disarm", mon_en, 0);
    pulse_clr();
    check("R7", "sts after ordered clear", fault_sts, 0);
    check("R7", "drv_en restored", drv_en, 1);
    check("R8", "capture cleared", fault_chan, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule